// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches the clock and data lines of a shared two-wire serial bus without ever driving them. It finds the three framing conditions of the bus: a start, a repeated start and a stop. From them it keeps a flag that says whether some master currently owns the bus. It is meant to sit next to a master or a target that needs to know the bus state before it acts, or that needs a clean per-bit strobe to build its own shift register.

Both lines pass through a synchronizer. Transitions are found by comparing each synchronized sample with the one taken a cycle earlier. A two-state machine, bus free and bus held, tells a first start apart from a repeated one. While the bus is held, a framing counter follows the bits on each rising clock edge. It marks each bit with its position in the nine-bit byte slot, which is eight data bits and then the acknowledge bit, and it raises a flag through the acknowledge bit.

States: `ST_FREE` (nobody owns the bus) and `ST_HELD` (a master owns it). Transitions: `ST_FREE` to `ST_HELD` on a start; `ST_HELD` to `ST_HELD` on a repeated start; `ST_HELD` to `ST_FREE` on a stop; a stop seen in `ST_FREE` is reported and leaves the state in `ST_FREE`.

Top module: `bus_cond_watch`

## Requirements
- R1: After reset, `bus_busy`, `ack_slot` and all pulse outputs are low and `bit_index` is 0. Both lines are taken as idle high, so releasing reset with both lines high reports no condition.
- R2: A falling data line while the clock line is high, with the bus free, gives a one-cycle `start_pulse`, and `bus_busy` is high in that same cycle.
- R3: The same transition while the bus is held gives a one-cycle `restart_pulse` and no `start_pulse`, and `bus_busy` stays high.
- R4: A rising data line while the clock line is high gives a one-cycle `stop_pulse`, and `bus_busy` is low in that cycle.
- R5: While the bus is held, each rising clock edge gives a one-cycle `bit_strobe`, with `bit_value` equal to the data line sampled at that edge. Data changes while the clock is low give no event. Rising clock edges while the bus is free give no strobe.
- R6: `bit_index` gives the position of the strobed bit inside its byte slot: 0 to 7 for the data bits, most significant first, and 8 for the acknowledge bit. After 8 it wraps to 0, so any number of bytes may follow one start.
- R7: `ack_slot` goes high with the strobe whose `bit_index` is 8. It stays high until the next strobe or the next condition.
- R8: A start or repeated start clears the framing, so the next strobe has `bit_index` 0 even in the middle of a byte. A stop also clears it.
- R9: A line change applied between clock edges shows up on the outputs after the third following rising edge of `clk`. That is two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, sampling both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_line | input | 1 | Bus clock line as seen at the pad |
| sda_line | input | 1 | Bus data line as seen at the pad |
| start_pulse | output | 1 | One-cycle pulse on a start from the free bus |
| restart_pulse | output | 1 | One-cycle pulse on a start while the bus is held |
| stop_pulse | output | 1 | One-cycle pulse on a stop |
| bus_busy | output | 1 | High while a master owns the bus |
| bit_strobe | output | 1 | One-cycle pulse per sampled bit |
| bit_value | output | 1 | Data line value at the last strobed bit |
| bit_index | output | IDX_W | Position of the last strobed bit in its nine-bit slot |
| ack_slot | output | 1 | High from the acknowledge-bit strobe until the next strobe or condition |

## Verification
The hardest case to reach is a repeated start in the middle of a byte. The clock must first rise with the data line high, and that rise is itself a sampled bit. Only after it does the data line fall to make the condition, and the framing must then restart at position 0. The stimulus builds this from line-level steps. It sends three data bits, releases the data line while the clock is low, raises the clock, and pulls the data line low. The scoreboard expects an extra bit, then the repeated start, then a new byte that counts from 0. Rising clock edges on a free bus, and data changes while the clock is low, are also sent, and the monitor must see no event for them.

// File: rtl/bus_cond_watch_pkg.sv
package bus_cond_watch_pkg;

    // Ownership state of the shared bus.
    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } bus_state_t;

    // Line events derived from two successive synchronized samples.
    typedef struct packed {
        logic start_cond;
        logic stop_cond;
        logic clk_rise;
        logic data_now;
    } line_evt_t;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync
    import bus_cond_watch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_raw,
    input  logic      sda_raw,
    output line_evt_t evt
);

    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 1;
    localparam int LINE_SDA  = 0;

    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] now_vec;
    logic [NUM_LINES-1:0] prev_vec;

    assign raw_vec = {scl_raw, sda_raw};

    // One synchronizer chain per line; reset value is the idle-high bus level.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], raw_vec[g]};
            end
        end

        assign now_vec[g] = chain_q[SYNC_STAGES-1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_vec[g] <= 1'b1;
            end else begin
                prev_vec[g] <= now_vec[g];
            end
        end
    end

    // Conditions need the clock line high in both samples.
    always_comb begin
        evt.start_cond = prev_vec[LINE_SCL] && now_vec[LINE_SCL]
                         && prev_vec[LINE_SDA] && !now_vec[LINE_SDA];
        evt.stop_cond  = prev_vec[LINE_SCL] && now_vec[LINE_SCL]
                         && !prev_vec[LINE_SDA] && now_vec[LINE_SDA];
        evt.clk_rise   = !prev_vec[LINE_SCL] && now_vec[LINE_SCL];
        evt.data_now   = now_vec[LINE_SDA];
    end

endmodule

// File: rtl/bus_cond_fsm.sv
module bus_cond_fsm
    import bus_cond_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_evt_t  evt,
    output bus_state_t state,
    output logic       start_pulse,
    output logic       restart_pulse,
    output logic       stop_pulse
);

    bus_state_t state_q;
    bus_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (evt.start_cond) state_d = ST_HELD;
            ST_HELD: if (evt.stop_cond)  state_d = ST_FREE;
            default: state_d = ST_FREE;
        endcase
    end

    // Registered condition pulses, aligned with the state they lead to.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse   <= 1'b0;
            restart_pulse <= 1'b0;
            stop_pulse    <= 1'b0;
        end else begin
            start_pulse   <= 1'b0;
            restart_pulse <= 1'b0;
            stop_pulse    <= evt.stop_cond;
            unique case (state_q)
                ST_FREE: start_pulse   <= evt.start_cond;
                ST_HELD: restart_pulse <= evt.start_cond;
                default: start_pulse   <= 1'b0;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/bus_bit_framer.sv
module bus_bit_framer
    import bus_cond_watch_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int IDX_W     = $clog2(DATA_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_evt_t        evt,
    input  bus_state_t       state,
    output logic             bit_strobe,
    output logic             bit_value,
    output logic [IDX_W-1:0] bit_index,
    output logic             ack_slot
);

    // The acknowledge bit follows the data bits.
    localparam logic [IDX_W-1:0] ACK_POS = IDX_W'(DATA_BITS);

    logic [IDX_W-1:0] next_pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pos_q <= '0;
            bit_strobe <= 1'b0;
            bit_value  <= 1'b0;
            bit_index  <= '0;
            ack_slot   <= 1'b0;
        end else begin
            bit_strobe <= 1'b0;
            if (evt.start_cond || evt.stop_cond) begin
                next_pos_q <= '0;
                ack_slot   <= 1'b0;
            end else if (evt.clk_rise && state == ST_HELD) begin
                bit_strobe <= 1'b1;
                bit_value  <= evt.data_now;
                bit_index  <= next_pos_q;
                ack_slot   <= (next_pos_q == ACK_POS);
                next_pos_q <= (next_pos_q == ACK_POS) ? '0 : next_pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_cond_watch.sv
module bus_cond_watch
    import bus_cond_watch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_BITS   = 8,
    parameter int IDX_W       = $clog2(DATA_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_line,
    input  logic             sda_line,
    output logic             start_pulse,
    output logic             restart_pulse,
    output logic             stop_pulse,
    output logic             bus_busy,
    output logic             bit_strobe,
    output logic             bit_value,
    output logic [IDX_W-1:0] bit_index,
    output logic             ack_slot
);

    line_evt_t  evt;
    bus_state_t state;

    bus_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_line),
        .sda_raw (sda_line),
        .evt     (evt)
    );

    bus_cond_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (evt),
        .state         (state),
        .start_pulse   (start_pulse),
        .restart_pulse (restart_pulse),
        .stop_pulse    (stop_pulse)
    );

    bus_bit_framer #(
        .DATA_BITS(DATA_BITS),
        .IDX_W    (IDX_W)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .state      (state),
        .bit_strobe (bit_strobe),
        .bit_value  (bit_value),
        .bit_index  (bit_index),
        .ack_slot   (ack_slot)
    );

    assign bus_busy = (state == ST_HELD);

endmodule

// File: rtl/bus_cond_watch_chk.sv
module bus_cond_watch_chk #(
    parameter int DATA_BITS = 8,
    parameter int IDX_W     = $clog2(DATA_BITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_pulse,
    input logic             restart_pulse,
    input logic             stop_pulse,
    input logic             bus_busy,
    input logic             bit_strobe,
    input logic [IDX_W-1:0] bit_index,
    input logic             ack_slot
);

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(DATA_BITS);

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> bus_busy);

    a_r2_start_from_free: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !$past(bus_busy));

    a_r3_restart_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (bus_busy && $past(bus_busy)));

    a_r4_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !bus_busy);

    a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, restart_pulse, stop_pulse, bit_strobe}));

    a_r5_no_bits_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> $past(bus_busy));

    a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (bit_index <= LAST_POS));

    a_r7_ack_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        ack_slot |-> (bit_index == LAST_POS));

    a_r8_cond_clears_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || restart_pulse || stop_pulse) |-> !ack_slot);

endmodule

bind bus_cond_watch bus_cond_watch_chk #(
    .DATA_BITS(DATA_BITS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_pulse   (start_pulse),
    .restart_pulse (restart_pulse),
    .stop_pulse    (stop_pulse),
    .bus_busy      (bus_busy),
    .bit_strobe    (bit_strobe),
    .bit_index     (bit_index),
    .ack_slot      (ack_slot)
);

// File: tb/bus_cond_watch_bench.sv
module bus_cond_watch_bench;

    localparam int IDX_W = 4;

    typedef enum int {EV_START, EV_RESTART, EV_STOP, EV_BIT} ev_kind_t;

    typedef struct {
        ev_kind_t kind;
        logic     val;
        int       idx;
        logic     ack;
        logic     busy;
        string    req;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_line = 1'b1;
    logic             sda_line = 1'b1;
    logic             start_pulse, restart_pulse, stop_pulse, bus_busy;
    logic             bit_strobe, bit_value, ack_slot;
    logic [IDX_W-1:0] bit_index;

    int        n_checks = 0;
    int        n_fail   = 0;
    int        n_events = 0;
    bit        done     = 1'b0;
    exp_item_t exp_q[$];

    // Bench-side model of bus ownership and bit position.
    bit m_busy = 1'b0;
    int m_pos  = 0;

    always #5 clk = ~clk;

    bus_cond_watch u_bus_cond_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_line      (scl_line),
        .sda_line      (sda_line),
        .start_pulse   (start_pulse),
        .restart_pulse (restart_pulse),
        .stop_pulse    (stop_pulse),
        .bus_busy      (bus_busy),
        .bit_strobe    (bit_strobe),
        .bit_value     (bit_value),
        .bit_index     (bit_index),
        .ack_slot      (ack_slot)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every observed event.
    always @(negedge clk) begin
        if (rst_n && !done && (start_pulse || restart_pulse || stop_pulse || bit_strobe)) begin
            ev_kind_t  k;
            exp_item_t e;
            n_events++;
            k = bit_strobe ? EV_BIT : start_pulse ? EV_START :
                restart_pulse ? EV_RESTART : EV_STOP;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected event kind", int'(k), -1);
            end else begin
                e = exp_q.pop_front();
                check(k == e.kind, e.req, "event kind", int'(k), int'(e.kind));
                check(bus_busy == e.busy, e.req, "bus_busy", int'(bus_busy), int'(e.busy));
                if (e.kind == EV_BIT && k == EV_BIT) begin
                    check(bit_value == e.val, "R5", "bit_value", int'(bit_value), int'(e.val));
                    check(int'(bit_index) == e.idx, "R6", "bit_index", int'(bit_index), e.idx);
                    check(ack_slot == e.ack, "R7", "ack_slot", int'(ack_slot), int'(e.ack));
                end
            end
        end
    end

    task automatic push(input ev_kind_t k, input logic v, input string req);
        exp_item_t e;
        e.kind = k; e.val = v; e.idx = m_pos; e.ack = (m_pos == 8);
        e.busy = (k != EV_STOP); e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic drive(input logic s_c, input logic s_d);
        if (s_c && !scl_line && m_busy) begin
            push(EV_BIT, s_d, "R6");
            m_pos = (m_pos == 8) ? 0 : m_pos + 1;
        end
        if (s_c && scl_line && sda_line && !s_d) begin
            push(m_busy ? EV_RESTART : EV_START, 1'b0, m_busy ? "R3" : "R2");
            m_busy = 1'b1; m_pos = 0;
        end
        if (s_c && scl_line && !sda_line && s_d) begin
            push(EV_STOP, 1'b0, "R4");
            m_busy = 1'b0; m_pos = 0;
        end
        scl_line = s_c;
        sda_line = s_d;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        drive(1'b0, v);
        drive(1'b1, v);
        drive(1'b0, v);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ackv);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(ackv);
    endtask

    initial begin : watchdog
        repeat (100000) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state, idle-high lines give no event
        check(!bus_busy, "R1", "bus_busy", int'(bus_busy), 0);
        check(!ack_slot, "R1", "ack_slot", int'(ack_slot), 0);
        check(bit_index == 0, "R1", "bit_index", int'(bit_index), 0);
        check(n_events == 0, "R1", "events after reset", n_events, 0);

        // R9: latency of a start, three rising edges after the change
        push(EV_START, 1'b0, "R2");
        m_busy = 1'b1; m_pos = 0;
        sda_line = 1'b0;
        repeat (2) @(negedge clk);
        check(!start_pulse, "R9", "start_pulse early", int'(start_pulse), 0);
        @(negedge clk);
        check(start_pulse, "R9", "start_pulse on time", int'(start_pulse), 1);
        @(negedge clk);
        check(!start_pulse, "R2", "start_pulse width", int'(start_pulse), 0);
        check(bus_busy, "R2", "bus_busy after start", int'(bus_busy), 1);
        repeat (3) @(negedge clk);
        drive(1'b0, 1'b0);

        // R6, R7: two full bytes
        send_byte(8'hA5, 1'b0);
        check(ack_slot, "R7", "ack_slot held after ack bit", int'(ack_slot), 1);
        send_bit(1'b1);
        check(!ack_slot, "R7", "ack_slot after next bit", int'(ack_slot), 0);
        for (int i = 6; i >= 0; i--) send_bit(i[0]);
        send_bit(1'b1);

        // R5: data toggles while clock low give no event
        seen = n_events;
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        check(n_events == seen, "R5", "events on low-clock data toggles", n_events - seen, 0);

        // R8, R3: repeated start in mid-byte
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        check(bus_busy, "R3", "bus_busy after restart", int'(bus_busy), 1);
        drive(1'b0, 1'b0);
        send_byte(8'h3C, 1'b1);

        // R4: stop
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        check(!bus_busy, "R4", "bus_busy after stop", int'(bus_busy), 0);
        check(!ack_slot, "R8", "ack_slot after stop", int'(ack_slot), 0);

        // R5: clock pulses on a free bus give no strobe
        seen = n_events;
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        check(n_events == seen, "R5", "events on free bus", n_events - seen, 0);

        // R2: a new start after stop is a first start
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        send_byte(8'h81, 1'b0);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R6", "events left unmatched", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule